// File: doc/BRIEF.md
# SPI Master Transaction Sequencer

This block is the control engine of an SPI master. It decides when the slave-select lines go active and when they go inactive. It spaces out the serial traffic with three programmable settling delays and counts the characters of each transaction. When a transaction ends and transmit data is still queued, it starts another one by itself. The bit shifter and the serial clock divider are separate blocks. The shifter receives one request per character and answers with a one-cycle completion pulse. For each character, the sequencer also tells the shifter whether to send zeros and whether to keep the received word.

Software raises a start request. The block then holds a start bit and a busy status for the whole burst of chained transactions. It emits one-cycle events when the selects become active, when they become inactive, and when the burst is finished. Each select line has its own polarity and can be included in the active set independently, so several slaves can be addressed at once. A hold option keeps the selects active after a transaction ends, so a later transaction can continue the same frame.

Top module: `spim_txn_seq`

## Requirements
- R1: After reset, busy, start and all three events are 0. Every select line sits at its inactive level, which is the inverse of its polarity bit.
- R2: While the selects are active, line i is driven to `sel_pol_i[i]` (1 = active high, 0 = active low) if `sel_mask_i[i]` is 1. Otherwise it stays at `~sel_pol_i[i]`. Any number of mask bits may be set at once.
- R3: The first character request is raised exactly L system clocks after the cycle in which the selects become active. L is `lead_dly_i`, and a value of 0 means 256.
- R4: A transaction carries max(`tx_num_i`, `rx_num_i`) characters. The character with index k (counting from 0) has `char_zero_o`=1 when k >= `tx_num_i` and `char_keep_o`=1 when k < `rx_num_i`. When both counts are 0, no request is raised.
- R5: After the last character completes, or after the lead delay when the length is 0, the transaction lasts T more clocks before it ends. T is `trail_dly_i`, and 0 means 256.
- R6: When a transaction ends with `txq_empty_i`=0, the block waits G clocks and then starts a new transaction with its own lead delay. G is `gap_dly_i`, and 0 means 256. When `txq_empty_i`=1 at the end, the block returns to idle.
- R7: With `hold_sel_i`=1 when a transaction ends, the selects stay active and no deactivation event is raised. With 0, the selects go inactive.
- R8: `start_o` and `busy_o` go to 1 in the cycle after an accepted start request. Both stay 1 across chained transactions and drop together in the cycle in which `ev_done_o` pulses for one clock.
- R9: `ev_ss_on_o` pulses for exactly one clock when the selects change from inactive to active. `ev_ss_off_o` pulses for exactly one clock when they change from active to inactive.
- R10: Nothing starts unless both `enable_i` and `master_i` are 1. If either is 0, the next cycle is idle with the selects inactive and start cleared, and no done event is raised.
- R11: A start request that arrives while the block is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Peripheral enable |
| master_i | input | 1 | Master-mode enable |
| start_set_i | input | 1 | One-cycle start request |
| hold_sel_i | input | 1 | Keep selects active after a transaction |
| sel_mask_i | input | NSS | Select lines to drive |
| sel_pol_i | input | NSS | Per-line polarity, 1 = active high |
| lead_dly_i | input | DLY_W | Select-active to first character delay |
| trail_dly_i | input | DLY_W | Last character to end-of-transaction delay |
| gap_dly_i | input | DLY_W | Delay between chained transactions |
| tx_num_i | input | CNT_W | Characters to transmit |
| rx_num_i | input | CNT_W | Characters to receive |
| txq_empty_i | input | 1 | Transmit FIFO is empty |
| char_done_i | input | 1 | Shifter finished the current character |
| char_req_o | output | 1 | Request a character from the shifter |
| char_zero_o | output | 1 | Current character is sent as zeros |
| char_keep_o | output | 1 | Current received character is stored |
| ss_o | output | NSS | Slave-select lines |
| start_o | output | 1 | Self-clearing start bit |
| busy_o | output | 1 | Transaction burst in progress |
| ev_ss_on_o | output | 1 | Selects became active |
| ev_ss_off_o | output | 1 | Selects became inactive |
| ev_done_o | output | 1 | Burst finished |

## Verification
The assertions check, on every cycle, the relations between the control outputs. Start never stands without busy. A done pulse always closes a busy period. A character request only appears while the selects are active. Each select event coincides with an actual change of the select state. A disable leads to idle on the next clock. Unselected lines stay at their inactive level, and the hold option suppresses the deactivation event. The lengths of the lead, trail and gap delays (including the 0-means-256 case), the character count and the zero and keep flags, and the chaining decision driven by the transmit FIFO can only be shown by the bench scenarios, which compare every output against a behavioural model on every clock.

// File: rtl/spim_seq_pkg.sv
package spim_seq_pkg;

   // sequencer phases
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LEAD  = 3'd1,
      PH_SHIFT = 3'd2,
      PH_TRAIL = 3'd3,
      PH_GAP   = 3'd4
   } phase_e;

endpackage

// File: rtl/spim_dly_timer.sv
// Shared down-counter for lead, trail and gap delays.
// A load value of N keeps expired_o low for N-1 cycles, so the phase lasts N
// cycles; N = 0 wraps to the full range (2**DLY_W cycles).
module spim_dly_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [DLY_W-1:0] val_i,
   output logic             expired_o
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i - ONE;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spim_char_ctr.sv
// Character index and per-character flags.
module spim_char_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] tx_num_i,
   input  logic [CNT_W-1:0] rx_num_i,
   output logic             none_o,
   output logic             last_o,
   output logic             tx_zero_o,
   output logic             rx_keep_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] len;

   assign len       = (tx_num_i > rx_num_i) ? tx_num_i : rx_num_i;
   assign none_o    = (len == '0);
   assign last_o    = (idx_q == (len - ONE));
   assign tx_zero_o = (idx_q >= tx_num_i);
   assign rx_keep_o = (idx_q < rx_num_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q <= '0;
      end else if (clear_i) begin
         idx_q <= '0;
      end else if (step_i) begin
         idx_q <= idx_q + ONE;
      end
   end
endmodule

// File: rtl/spim_sel_drive.sv
// Per-line select level from the common active state, mask and polarity.
module spim_sel_drive #(
   parameter int NSS = 3
) (
   input  logic           active_i,
   input  logic [NSS-1:0] mask_i,
   input  logic [NSS-1:0] pol_i,
   output logic [NSS-1:0] ss_o
);
   for (genvar i = 0; i < NSS; i++) begin : g_line
      assign ss_o[i] = (active_i & mask_i[i]) ? pol_i[i] : ~pol_i[i];
   end
endmodule

// File: rtl/spim_txn_seq.sv
module spim_txn_seq
   import spim_seq_pkg::*;
#(
   parameter int NSS   = 3,
   parameter int DLY_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             master_i,
   input  logic             start_set_i,
   input  logic             hold_sel_i,
   input  logic [NSS-1:0]   sel_mask_i,
   input  logic [NSS-1:0]   sel_pol_i,
   input  logic [DLY_W-1:0] lead_dly_i,
   input  logic [DLY_W-1:0] trail_dly_i,
   input  logic [DLY_W-1:0] gap_dly_i,
   input  logic [CNT_W-1:0] tx_num_i,
   input  logic [CNT_W-1:0] rx_num_i,
   input  logic             txq_empty_i,
   input  logic             char_done_i,
   output logic             char_req_o,
   output logic             char_zero_o,
   output logic             char_keep_o,
   output logic [NSS-1:0]   ss_o,
   output logic             start_o,
   output logic             busy_o,
   output logic             ev_ss_on_o,
   output logic             ev_ss_off_o,
   output logic             ev_done_o
);
   // elaboration-time parameter checks
   if (NSS < 1 || NSS > 32) begin : g_bad_nss
      $error("spim_txn_seq: NSS must be 1..32");
   end
   if (DLY_W < 2 || DLY_W > 16) begin : g_bad_dly
      $error("spim_txn_seq: DLY_W must be 2..16");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("spim_txn_seq: CNT_W must be 1..32");
   end

   phase_e ph_q, ph_d;
   logic   sel_act_q, sel_act_d;
   logic   start_q, start_d;
   logic   ev_on_q, ev_on_d;
   logic   ev_off_q, ev_off_d;
   logic   ev_done_q, ev_done_d;

   logic             tmr_load;
   logic [DLY_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             ctr_clear, ctr_step;
   logic             ctr_none, ctr_last, ctr_zero, ctr_keep;
   logic             run;

   assign run = enable_i & master_i;

   spim_dly_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load),
      .val_i     (tmr_val),
      .expired_o (tmr_exp)
   );

   spim_char_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (ctr_clear),
      .step_i    (ctr_step),
      .tx_num_i  (tx_num_i),
      .rx_num_i  (rx_num_i),
      .none_o    (ctr_none),
      .last_o    (ctr_last),
      .tx_zero_o (ctr_zero),
      .rx_keep_o (ctr_keep)
   );

   spim_sel_drive #(.NSS(NSS)) u_sel (
      .active_i (sel_act_q),
      .mask_i   (sel_mask_i),
      .pol_i    (sel_pol_i),
      .ss_o     (ss_o)
   );

   always_comb begin
      ph_d      = ph_q;
      sel_act_d = sel_act_q;
      start_d   = start_q;
      ev_on_d   = 1'b0;
      ev_off_d  = 1'b0;
      ev_done_d = 1'b0;
      tmr_load  = 1'b0;
      tmr_val   = lead_dly_i;
      ctr_clear = 1'b0;
      ctr_step  = 1'b0;
      if (!run) begin
         ph_d      = PH_IDLE;
         sel_act_d = 1'b0;
         start_d   = 1'b0;
         ev_off_d  = sel_act_q;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (start_set_i) begin
                  ph_d      = PH_LEAD;
                  tmr_load  = 1'b1;
                  tmr_val   = lead_dly_i;
                  start_d   = 1'b1;
                  sel_act_d = 1'b1;
                  ev_on_d   = ~sel_act_q;
                  ctr_clear = 1'b1;
               end
            end
            PH_LEAD: begin
               if (tmr_exp) begin
                  if (ctr_none) begin
                     ph_d     = PH_TRAIL;
                     tmr_load = 1'b1;
                     tmr_val  = trail_dly_i;
                  end else begin
                     ph_d = PH_SHIFT;
                  end
               end
            end
            PH_SHIFT: begin
               if (char_done_i) begin
                  ctr_step = 1'b1;
                  if (ctr_last) begin
                     ph_d     = PH_TRAIL;
                     tmr_load = 1'b1;
                     tmr_val  = trail_dly_i;
                  end
               end
            end
            PH_TRAIL: begin
               if (tmr_exp) begin
                  if (!hold_sel_i) begin
                     sel_act_d = 1'b0;
                     ev_off_d  = sel_act_q;
                  end
                  if (!txq_empty_i) begin
                     ph_d     = PH_GAP;
                     tmr_load = 1'b1;
                     tmr_val  = gap_dly_i;
                  end else begin
                     ph_d      = PH_IDLE;
                     start_d   = 1'b0;
                     ev_done_d = 1'b1;
                  end
               end
            end
            PH_GAP: begin
               if (tmr_exp) begin
                  ph_d      = PH_LEAD;
                  tmr_load  = 1'b1;
                  tmr_val   = lead_dly_i;
                  sel_act_d = 1'b1;
                  ev_on_d   = ~sel_act_q;
                  ctr_clear = 1'b1;
               end
            end
            default: ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q      <= PH_IDLE;
         sel_act_q <= 1'b0;
         start_q   <= 1'b0;
         ev_on_q   <= 1'b0;
         ev_off_q  <= 1'b0;
         ev_done_q <= 1'b0;
      end else begin
         ph_q      <= ph_d;
         sel_act_q <= sel_act_d;
         start_q   <= start_d;
         ev_on_q   <= ev_on_d;
         ev_off_q  <= ev_off_d;
         ev_done_q <= ev_done_d;
      end
   end

   assign char_req_o  = (ph_q == PH_SHIFT);
   assign char_zero_o = char_req_o & ctr_zero;
   assign char_keep_o = char_req_o & ctr_keep;
   assign busy_o      = (ph_q != PH_IDLE);
   assign start_o     = start_q;
   assign ev_ss_on_o  = ev_on_q;
   assign ev_ss_off_o = ev_off_q;
   assign ev_done_o   = ev_done_q;
endmodule

// File: rtl/spim_txn_seq_chk.sv
module spim_txn_seq_chk #(
   parameter int NSS = 3
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           enable_i,
   input logic           master_i,
   input logic           hold_sel_i,
   input logic [NSS-1:0] sel_pol_i,
   input logic [NSS-1:0] ss_o,
   input logic           sel_act_q,
   input logic           char_req_o,
   input logic           start_o,
   input logic           busy_o,
   input logic           ev_ss_on_o,
   input logic           ev_ss_off_o,
   input logic           ev_done_o
);
   AST_START_WITHIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |-> busy_o);  // R8
   AST_DONE_CLOSES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_done_o |-> (!busy_o && !start_o && $past(busy_o)));  // R8
   AST_REQ_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      char_req_o |-> (busy_o && sel_act_q));  // R4
   AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(enable_i && master_i) |=> (!busy_o && !sel_act_q && !start_o && !ev_done_o));  // R10
   AST_ON_EVENT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_ss_on_o |-> (sel_act_q && !$past(sel_act_q)));  // R9
   AST_OFF_EVENT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_ss_off_o |-> (!sel_act_q && $past(sel_act_q)));  // R9
   AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ev_ss_on_o && ev_ss_off_o));  // R9
   AST_HOLD_NO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_done_o && $past(hold_sel_i)) |-> !ev_ss_off_o);  // R7
   AST_INACTIVE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_act_q |-> (ss_o == ~sel_pol_i));  // R1
endmodule

bind spim_txn_seq spim_txn_seq_chk #(.NSS(NSS)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .enable_i    (enable_i),
   .master_i    (master_i),
   .hold_sel_i  (hold_sel_i),
   .sel_pol_i   (sel_pol_i),
   .ss_o        (ss_o),
   .sel_act_q   (sel_act_q),
   .char_req_o  (char_req_o),
   .start_o     (start_o),
   .busy_o      (busy_o),
   .ev_ss_on_o  (ev_ss_on_o),
   .ev_ss_off_o (ev_ss_off_o),
   .ev_done_o   (ev_done_o)
);

// File: tb/spim_txn_seq_tb_top.sv
module spim_txn_seq_tb_top;
   localparam int NSS = 3;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic           enable = 1'b0, master = 1'b0, start_set = 1'b0, hold = 1'b0;
   logic [NSS-1:0] mask = '0, pol = 3'b010;
   logic [7:0]     lead = 8'd3, trail = 8'd2, gap = 8'd4;
   logic [15:0]    tx_num = 16'd0, rx_num = 16'd0;
   logic           char_done = 1'b0;
   int             fifo_cnt = 0;
   logic           txq_empty;
   assign txq_empty = (fifo_cnt == 0);

   logic           req, zero, keep, start_o, busy, ev_on, ev_off, ev_done;
   logic [NSS-1:0] ss;

   spim_txn_seq #(.NSS(NSS), .DLY_W(8), .CNT_W(16)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .master_i(master),
      .start_set_i(start_set), .hold_sel_i(hold), .sel_mask_i(mask), .sel_pol_i(pol),
      .lead_dly_i(lead), .trail_dly_i(trail), .gap_dly_i(gap),
      .tx_num_i(tx_num), .rx_num_i(rx_num), .txq_empty_i(txq_empty),
      .char_done_i(char_done), .char_req_o(req), .char_zero_o(zero), .char_keep_o(keep),
      .ss_o(ss), .start_o(start_o), .busy_o(busy),
      .ev_ss_on_o(ev_on), .ev_ss_off_o(ev_off), .ev_done_o(ev_done)
   );

   int n_chk = 0, n_err = 0;
   task automatic chk(string rq, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_ph = 0, m_left = 0, m_idx = 0;
   bit m_sel = 0, m_start = 0, m_on = 0, m_off = 0, m_done = 0;

   function automatic int dly(logic [7:0] v);
      return (v == 0) ? 256 : int'(v);
   endfunction
   function automatic int maxlen();
      return (tx_num > rx_num) ? int'(tx_num) : int'(rx_num);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_idx = 0;
         m_sel = 0; m_start = 0; m_on = 0; m_off = 0; m_done = 0;
      end else begin
         m_on = 0; m_off = 0; m_done = 0;
         if (!(enable && master)) begin
            m_off = m_sel; m_sel = 0; m_ph = 0; m_start = 0;
         end else begin
            case (m_ph)
               0: if (start_set) begin
                     m_ph = 1; m_left = dly(lead); m_start = 1;
                     m_on = !m_sel; m_sel = 1;
                  end
               1: begin
                     m_left--;
                     if (m_left == 0) begin
                        m_idx = 0;
                        if (maxlen() == 0) begin m_ph = 3; m_left = dly(trail); end
                        else m_ph = 2;
                     end
                  end
               2: if (char_done) begin
                     m_idx++;
                     if (m_idx == maxlen()) begin m_ph = 3; m_left = dly(trail); end
                  end
               3: begin
                     m_left--;
                     if (m_left == 0) begin
                        if (!hold) begin m_off = m_sel; m_sel = 0; end
                        if (fifo_cnt != 0) begin m_ph = 4; m_left = dly(gap); end
                        else begin m_ph = 0; m_start = 0; m_done = 1; end
                     end
                  end
               4: begin
                     m_left--;
                     if (m_left == 0) begin
                        m_ph = 1; m_left = dly(lead);
                        m_on = !m_sel; m_sel = 1;
                     end
                  end
               default: m_ph = 0;
            endcase
         end
      end
   end

   // ---------------- per-clock comparison, monitors, shifter ----------------
   int cnt_on = 0, cnt_off = 0, cnt_done = 0, n_chars = 0, n_zero = 0, sh_cnt = 0;
   bit cmp_en = 0;

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R8", "busy", busy, m_ph != 0);
         chk("R8", "start", start_o, m_start);
         for (int i = 0; i < NSS; i++)
            chk("R2", "select line", ss[i], (m_sel && mask[i]) ? pol[i] : !pol[i]);
         chk("R4", "char_req", req, m_ph == 2);
         chk("R4", "char_zero", zero, (m_ph == 2) && (m_idx >= tx_num));
         chk("R4", "char_keep", keep, (m_ph == 2) && (m_idx < rx_num));
         chk("R9", "ev_ss_on", ev_on, m_on);
         chk("R9", "ev_ss_off", ev_off, m_off);
         chk("R8", "ev_done", ev_done, m_done);
         cnt_on += ev_on; cnt_off += ev_off; cnt_done += ev_done;
      end
      #1;
      if (req) begin
         if (sh_cnt == LAT - 1) begin
            char_done = 1'b1; sh_cnt = 0; n_chars++;
            if (zero) n_zero++;
            else if (fifo_cnt > 0) fifo_cnt--;
         end else begin
            char_done = 1'b0; sh_cnt++;
         end
      end else begin
         char_done = 1'b0; sh_cnt = 0;
      end
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick(int n = 1);
      repeat (n) begin @(negedge clk); #2; end
   endtask
   task automatic go();
      start_set = 1'b1; tick(); start_set = 1'b0;
   endtask
   task automatic wait_idle();
      int g = 0;
      while (busy && g < 20000) begin tick(); g++; end
      tick(2);
   endtask

   initial begin
      int k, b0, d0, o0, f0, c0, z0;
      tick(3);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      tick();
      // R1: reset state
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "start after reset", start_o, 0);
      chk("R1", "idle select levels", ss, 3'b101);
      chk("R1", "events after reset", {ev_on, ev_off, ev_done}, 0);

      enable = 1'b1; master = 1'b1;
      // basic transaction, active-low line 0
      mask = 3'b001; pol = 3'b000; lead = 8'd3; trail = 8'd2; gap = 8'd4;
      tx_num = 16'd2; rx_num = 16'd2; fifo_cnt = 2;
      d0 = cnt_done; c0 = n_chars;
      tick(); go();
      chk("R2", "active-low line asserted", ss, 3'b110);
      k = 0;
      while (!req && k < 400) begin tick(); k++; end
      chk("R3", "lead delay cycles", k, 3);
      wait_idle();
      chk("R4", "characters in basic transaction", n_chars - c0, 2);
      chk("R8", "one done event", cnt_done - d0, 1);

      // mixed polarity and zero fill: tx 1, rx 3
      mask = 3'b110; pol = 3'b100; tx_num = 16'd1; rx_num = 16'd3; fifo_cnt = 1;
      c0 = n_chars; z0 = n_zero;
      tick(); go();
      chk("R2", "mixed polarity lines", ss, 3'b101);
      wait_idle();
      chk("R4", "length is max of counts", n_chars - c0, 3);
      chk("R4", "zero-filled characters", n_zero - z0, 2);

      // zero length with lead 5 and trail 0 (256)
      tx_num = 16'd0; rx_num = 16'd0; lead = 8'd5; trail = 8'd0;
      c0 = n_chars;
      tick(); go();
      b0 = 0;
      while (busy && b0 < 2000) begin tick(); b0++; end
      chk("R5", "busy span lead+trail(256)", b0, 261);
      chk("R4", "no characters at zero length", n_chars - c0, 0);
      tick(2);

      // lead 0 means 256
      lead = 8'd0; trail = 8'd2; tx_num = 16'd1; fifo_cnt = 0;
      tick(); go();
      k = 0;
      while (!req && k < 1000) begin tick(); k++; end
      chk("R3", "lead 0 gives 256 cycles", k, 256);
      wait_idle();

      // chaining while FIFO non-empty
      lead = 8'd2; gap = 8'd3; tx_num = 16'd2; rx_num = 16'd0; fifo_cnt = 5; mask = 3'b001;
      o0 = cnt_on; f0 = cnt_off; d0 = cnt_done; c0 = n_chars;
      tick(); go();
      wait_idle();
      chk("R6", "chained transactions", cnt_on - o0, 3);
      chk("R6", "deassert between transactions", cnt_off - f0, 3);
      chk("R6", "characters over chain", n_chars - c0, 6);
      chk("R8", "single done for chain", cnt_done - d0, 1);

      // hold option
      hold = 1'b1; mask = 3'b010; pol = 3'b010; tx_num = 16'd1; fifo_cnt = 0;
      f0 = cnt_off; o0 = cnt_on;
      tick(); go();
      wait_idle();
      chk("R7", "select held after end", ss, 3'b111);
      chk("R7", "no deassert event with hold", cnt_off - f0, 0);
      hold = 1'b0;
      tick(); go();
      wait_idle();
      chk("R9", "no assert event while held", cnt_on - o0, 1);
      chk("R9", "deassert event after release", cnt_off - f0, 1);
      chk("R7", "select released", ss, 3'b101);

      // start while busy is ignored
      tx_num = 16'd2; d0 = cnt_done; o0 = cnt_on;
      tick(); go();
      tick(3);
      go();
      wait_idle();
      chk("R11", "start while busy: one done", cnt_done - d0, 1);
      chk("R11", "start while busy: one activation", cnt_on - o0, 1);
      chk("R11", "idle after ignored start", busy, 0);

      // abort by disable mid-transfer
      tx_num = 16'd4; d0 = cnt_done;
      tick(); go();
      tick(8);
      enable = 1'b0;
      tick();
      chk("R10", "busy cleared on disable", busy, 0);
      chk("R10", "start cleared on disable", start_o, 0);
      chk("R10", "selects inactive on disable", ss, 3'b101);
      chk("R10", "no done on abort", cnt_done - d0, 0);
      go(); tick();
      chk("R10", "start ignored while disabled", busy, 0);
      enable = 1'b1; master = 1'b0;
      go(); tick();
      chk("R10", "start ignored without master mode", busy, 0);
      master = 1'b1;
      tick(3);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule